// File: doc/BRIEF.md
# Sampling converter conversion and readout sequencer

This block is the digital control of a sampling converter. A falling edge on the active-low start strobe takes a snapshot of the 16-bit sample input (the hold moment) and begins a conversion of fixed length counted in system clock cycles. While the conversion runs, `busy` stays high. When the count ends, the held sample becomes the new result and `busy` falls. That falling edge is the data-ready event.

The result can be read two ways. The parallel port presents all bits at once. The serial slave port shifts the result out MSB first on rising edges of an externally supplied serial clock, and raises a frame-sync of selectable polarity while serial data is valid. Both ports drive only while chip-select and read are both low. If a new conversion finishes while a serial frame is still open, that frame is abandoned and a one-cycle read-error pulse is raised. Power-down blocks new conversions but lets one in flight finish. Reset aborts a conversion and clears the result.

Two state machines do the work. The conversion machine has the states CV_IDLE and CV_RUN. It moves from CV_IDLE to CV_RUN on an accepted start, and from CV_RUN back to CV_IDLE when the counter reaches its last value. The read machine has the states RD_IDLE, RD_SHIFT and RD_DONE:
- RD_IDLE to RD_SHIFT when a serial read is enabled and no conversion completes in that cycle.
- RD_SHIFT to RD_DONE on the last serial clock rise.
- RD_SHIFT to RD_IDLE when a conversion completes, which is the error abort.
- RD_DONE to RD_IDLE when the read enable is removed.

All inputs are taken as synchronous to `clk`.

Top module: `sar_seq`

## Requirements
- R1: A falling edge on `conv_n` (high in one cycle, low in the next) while `busy` is low and `pd` is low makes `busy` high from the following cycle for exactly CONV_CYCLES cycles.
- R2: When `busy` falls, the result equals the value `adc_in` had at the clock edge that accepted the start. Later changes of `adc_in` have no effect on it.
- R3: A falling edge on `conv_n` while `busy` is high is ignored: the busy period is not lengthened and the result is not changed.
- R4: While `pd` is high, falling edges on `conv_n` start nothing (`busy` stays low). A conversion already running when `pd` rises completes normally.
- R5: `par_oe` is high exactly when `ser_mode`=0, `cs_n`=0 and `rd_n`=0. `par_data` then equals the latest result, and is all zeros otherwise.
- R6: With `ser_mode`=1, `cs_n`=0 and `rd_n`=0, a frame opens in the next cycle with `sdout` equal to result bit 15. Each rising edge of `sclk` seen while `cs_n`=0 advances to the next lower bit. Edges while `cs_n`=1 do not advance, and `sdout` is 0 whenever the serial read is not enabled.
- R7: `sync` equals `~inv_sync` while a frame is open and the serial read is enabled, and `inv_sync` otherwise. The frame closes on the 16th accepted `sclk` rise.
- R8: If a conversion completes while a frame is open, `rd_err` is high for exactly the one cycle in which `busy` first reads low. The frame closes, and a new frame then delivers the new result.
- R9: Synchronous active-high `rst` aborts any conversion. After reset, `busy`=0, `rd_err`=0, `sync`=`inv_sync`, and the result reads as zero.
- R10: Both read ports work normally while `pd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Conversion start strobe, falling edge active |
| pd | input | 1 | Power-down: inhibits new conversions |
| adc_in | input | 16 | Sample value captured at hold |
| busy | output | 1 | High while a conversion runs |
| ser_mode | input | 1 | 1 selects serial read, 0 selects parallel read |
| cs_n | input | 1 | Chip-select, active low; also gates `sclk` |
| rd_n | input | 1 | Read, active low |
| sclk | input | 1 | External serial clock, rising edge shifts |
| inv_sync | input | 1 | 1 makes `sync` active low |
| sdout | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame sync while serial data is valid |
| rd_err | output | 1 | One-cycle pulse when an open frame is overrun |
| par_oe | output | 1 | Parallel port enable |
| par_data | output | 16 | Parallel result, zero when not enabled |

## Verification
The bench drives a second start edge into a running conversion and changes `adc_in` at the same time. A design that re-armed on that edge would stretch `busy` or latch the wrong sample. It also lets a conversion finish in the middle of a serial frame. A design that missed the overrun would give no `rd_err` pulse, keep `sync` asserted, or keep shifting stale bits instead of the new result. Further cases pulse `sclk` while `cs_n` is high, which a design without clock gating would count as a shifted bit. Others raise `pd` during a conversion and assert reset in mid-flight, which would expose a design that aborted on power-down or kept a stale result. Random values, polarities and port choices fill in the common path.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic {
        CV_IDLE,
        CV_RUN
    } conv_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_SHIFT,
        RD_DONE
    } rd_state_t;

endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge #(
    parameter bit DETECT_RISE = 1'b1,
    parameter bit IDLE_LVL    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    input  logic gate,
    output logic pulse
);

    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= IDLE_LVL;
        end else begin
            sig_q <= sig;
        end
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign pulse = gate & sig & ~sig_q;
        end else begin : g_fall
            assign pulse = gate & ~sig & sig_q;
        end
    endgenerate

endmodule

// File: rtl/sar_seq_conv.sv
module sar_seq_conv
    import sar_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pd,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    conv_state_t       state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] held;
    logic              accept;
    logic              at_last;

    assign accept  = start & ~pd;
    assign at_last = (cnt == CNT_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CV_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CV_IDLE: if (accept)  state_nx = CV_RUN;
            CV_RUN:  if (at_last) state_nx = CV_IDLE;
            default: state_nx = CV_IDLE;
        endcase
    end

    // counter, hold and result
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            held   <= '0;
            result <= '0;
        end else begin
            unique case (state)
                CV_IDLE: begin
                    if (accept) begin
                        held <= sample_in;
                        cnt  <= '0;
                    end
                end
                CV_RUN: begin
                    cnt <= cnt + CNT_W'(1);
                    if (at_last) begin
                        result <= held;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state == CV_RUN);
        done = (state == CV_RUN) && at_last;
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !pd && !busy) |=> busy); // R1
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(result)); // R2
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy); // R3
    AST_PD_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (pd && !busy) |=> !busy); // R4

endmodule

// File: rtl/sar_seq_serial.sv
module sar_seq_serial
    import sar_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              inv_sync,
    input  logic              sclk_rise,
    input  logic              done,
    input  logic [DATA_W-1:0] result,
    output logic              sdout,
    output logic              sync,
    output logic              rd_err
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rd_state_t         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              en;
    logic              frame_on;

    assign en = ser_mode & ~cs_n & ~rd_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: begin
                if (en && !done) state_nx = RD_SHIFT;
            end
            RD_SHIFT: begin
                if (done)                               state_nx = RD_IDLE;
                else if (sclk_rise && idx == IDX_LAST)  state_nx = RD_DONE;
            end
            RD_DONE: begin
                if (!en) state_nx = RD_IDLE;
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    // shift register, bit index and error pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            idx    <= '0;
            rd_err <= 1'b0;
        end else begin
            rd_err <= (state == RD_SHIFT) && done;
            unique case (state)
                RD_IDLE: begin
                    if (en && !done) begin
                        shreg <= result;
                        idx   <= '0;
                    end
                end
                RD_SHIFT: begin
                    if (!done && sclk_rise) begin
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        idx   <= idx + IDX_W'(1);
                    end
                end
                RD_DONE: idx <= idx;
                default: idx <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        frame_on = (state == RD_SHIFT);
        sdout    = en & frame_on & shreg[DATA_W-1];
        sync     = (en & frame_on) ^ inv_sync;
    end

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> !rd_err); // R8
    AST_SYNC_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (sync == inv_sync)); // R7
    AST_SDOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode || cs_n || rd_n) |-> !sdout); // R6
    AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !done) |=> $stable(idx)); // R6

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_n,
    input  logic              pd,
    input  logic [DATA_W-1:0] adc_in,
    output logic              busy,
    input  logic              ser_mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              sclk,
    input  logic              inv_sync,
    output logic              sdout,
    output logic              sync,
    output logic              rd_err,
    output logic              par_oe,
    output logic [DATA_W-1:0] par_data
);

    logic              start_pulse;
    logic              sclk_rise;
    logic              conv_done;
    logic [DATA_W-1:0] result;

    sar_seq_edge #(.DETECT_RISE(1'b0), .IDLE_LVL(1'b0)) u_start_edge (
        .clk   (clk),
        .rst   (rst),
        .sig   (conv_n),
        .gate  (1'b1),
        .pulse (start_pulse)
    );

    sar_seq_edge #(.DETECT_RISE(1'b1), .IDLE_LVL(1'b1)) u_sclk_edge (
        .clk   (clk),
        .rst   (rst),
        .sig   (sclk),
        .gate  (~cs_n),
        .pulse (sclk_rise)
    );

    sar_seq_conv #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk       (clk),
        .rst       (rst),
        .start     (start_pulse),
        .pd        (pd),
        .sample_in (adc_in),
        .busy      (busy),
        .done      (conv_done),
        .result    (result)
    );

    sar_seq_serial #(.DATA_W(DATA_W)) u_serial (
        .clk       (clk),
        .rst       (rst),
        .ser_mode  (ser_mode),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .inv_sync  (inv_sync),
        .sclk_rise (sclk_rise),
        .done      (conv_done),
        .result    (result),
        .sdout     (sdout),
        .sync      (sync),
        .rd_err    (rd_err)
    );

    always_comb begin
        par_oe   = ~ser_mode & ~cs_n & ~rd_n;
        par_data = par_oe ? result : '0;
    end

    AST_ERR_AT_COMPLETION: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> $fell(busy)); // R8
    AST_PAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !par_oe |-> (par_data == '0)); // R5
    AST_SERIAL_NOT_PARALLEL: assert property (@(posedge clk) disable iff (rst)
        ser_mode |-> !par_oe); // R5

endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;

    localparam int W    = 16;
    localparam int CONV = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_n = 1'b1;
    logic         pd = 1'b0;
    logic [W-1:0] adc_in = '0;
    logic         busy;
    logic         ser_mode = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         sclk = 1'b0;
    logic         inv_sync = 1'b0;
    logic         sdout;
    logic         sync;
    logic         rd_err;
    logic         par_oe;
    logic [W-1:0] par_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    sar_seq #(.DATA_W(W), .CONV_CYCLES(CONV)) u_sar_seq (
        .clk(clk), .rst(rst), .conv_n(conv_n), .pd(pd), .adc_in(adc_in),
        .busy(busy), .ser_mode(ser_mode), .cs_n(cs_n), .rd_n(rd_n),
        .sclk(sclk), .inv_sync(inv_sync), .sdout(sdout), .sync(sync),
        .rd_err(rd_err), .par_oe(par_oe), .par_data(par_data)
    );

    function automatic logic exp_bit(input logic [W-1:0] v, input int i);
        return v[W-1-i];
    endfunction

    function automatic logic exp_sync(input logic active, input logic inv);
        return active ^ inv;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // start a conversion; optional second strobe and pd rise at given busy cycles
    task automatic run_conv(input logic [W-1:0] v, input int glitch_at, input int pd_at,
                            output int len);
        @(negedge clk);
        adc_in = v;
        conv_n = 1'b1;
        @(negedge clk);
        conv_n = 1'b0;
        @(negedge clk);
        adc_in = ~v;
        len = 0;
        while (busy && len < CONV + 10) begin
            len++;
            if (len == glitch_at) conv_n = 1'b1;
            if (len == glitch_at + 1) begin
                conv_n = 1'b0;
                adc_in = v ^ 16'h5a5a;
            end
            if (len == pd_at) pd = 1'b1;
            @(negedge clk);
        end
        conv_n = 1'b1;
    endtask

    task automatic read_par(input logic [W-1:0] exp, input string req);
        ser_mode = 1'b0;
        cs_n = 1'b0;
        rd_n = 1'b0;
        @(negedge clk);
        chk(req, par_data, exp);
        chk("R5 oe", par_oe, 1'b1);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R5 quiet", {par_oe, par_data}, '0);
        cs_n = 1'b1;
    endtask

    task automatic clk_pulse();
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_ser(input logic [W-1:0] exp, input logic inv, input int stall_at,
                            input string req);
        ser_mode = 1'b1;
        inv_sync = inv;
        sclk = 1'b0;
        cs_n = 1'b0;
        rd_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < W; i++) begin
            if (i == stall_at) begin
                cs_n = 1'b1;
                @(negedge clk);
                chk("R6 deselected sdout", sdout, 1'b0);
                chk("R7 deselected sync", sync, exp_sync(1'b0, inv));
                clk_pulse();
                cs_n = 1'b0;
                @(negedge clk);
            end
            chk(req, sdout, exp_bit(exp, i));
            chk("R7 sync active", sync, exp_sync(1'b1, inv));
            clk_pulse();
        end
        chk("R7 frame closed", sync, exp_sync(1'b0, inv));
        chk("R6 sdout after frame", sdout, 1'b0);
        cs_n = 1'b1;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int len;
        logic [W-1:0] a;
        logic [W-1:0] b;
        void'($urandom(32'h5EED));

        // reset state
        repeat (3) @(negedge clk);
        chk("R9 busy in reset", busy, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 busy", busy, 1'b0);
        chk("R9 rd_err", rd_err, 1'b0);
        chk("R9 sync", sync, exp_sync(1'b0, 1'b0));
        read_par('0, "R9 result zero");

        // basic conversion, R1 and R2
        run_conv(16'hA53C, -5, -5, len);
        chk("R1 busy length", len, CONV);
        read_par(16'hA53C, "R2 result");

        // second strobe during busy, R3
        run_conv(16'h1234, 6, -5, len);
        chk("R3 busy length", len, CONV);
        read_par(16'h1234, "R3 result unchanged");

        // power-down mid conversion finishes, R4
        run_conv(16'hBEEF, -5, 4, len);
        chk("R4 in-flight length", len, CONV);
        read_par(16'hBEEF, "R4 in-flight result");
        // strobe under power-down is ignored
        adc_in = 16'h0F0F;
        conv_n = 1'b0;
        @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            chk("R4 start blocked", busy, 1'b0);
        end
        conv_n = 1'b1;
        // reading during power-down, R10
        read_par(16'hBEEF, "R10 parallel in pd");
        read_ser(16'hBEEF, 1'b0, -1, "R10 serial in pd");
        pd = 1'b0;

        // serial with deselect stall and inverted sync, R6 R7
        read_ser(16'hBEEF, 1'b1, 5, "R6 serial bit");

        // overrun of an open frame, R8
        a = 16'h6C91;
        @(negedge clk);
        adc_in = a;
        conv_n = 1'b1;
        @(negedge clk);
        conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1;
        ser_mode = 1'b1;
        inv_sync = 1'b0;
        cs_n = 1'b0;
        rd_n = 1'b0;
        @(negedge clk);
        chk("R6 stale msb", sdout, exp_bit(16'hBEEF, 0));
        clk_pulse();
        clk_pulse();
        clk_pulse();
        chk("R6 stale bit3", sdout, exp_bit(16'hBEEF, 3));
        while (busy) @(negedge clk);
        chk("R8 error pulse", rd_err, 1'b1);
        chk("R8 frame closed", sync, 1'b0);
        @(negedge clk);
        chk("R8 pulse width", rd_err, 1'b0);
        read_ser(a, 1'b0, -1, "R8 new data");

        // no error when no frame is open, R8
        run_conv(16'h0101, -5, -5, len);
        chk("R8 no spurious error", rd_err, 1'b0);

        // reset mid conversion, R9
        @(negedge clk);
        adc_in = 16'hFFFF;
        conv_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 running", busy, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        conv_n = 1'b1;
        @(negedge clk);
        chk("R9 aborted", busy, 1'b0);
        chk("R9 sync", sync, 1'b0);
        repeat (CONV + 2) @(negedge clk);
        read_par('0, "R9 cleared result");

        // random mix
        for (int k = 0; k < 12; k++) begin
            b = W'($urandom);
            run_conv(b, -5, -5, len);
            chk("R1 random length", len, CONV);
            if ($urandom % 2 == 0) read_par(b, "R2 random parallel");
            else read_ser(b, 1'($urandom), -1, "R6 random serial");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule